// File: doc/BRIEF.md
# Systolic 3x3 Integer Matrix Multiplier

This block computes the product C = A x B of two square matrices of signed integers on a two-dimensional grid of multiply-accumulate cells. Each cell owns one result element and keeps it in its own accumulator, so results never move. A start pulse captures both operand matrices from wide parallel buses. Two skew feeders then inject the operands. Each row of A enters at the left edge of the grid. Each column of B enters at the top edge. Row r and column c are held back by r and c steps, so matching operands meet in the right cell.

Every cell latches the operand pair that arrives, forwards the A value to its right neighbour and the B value to the cell below, and adds the product to its accumulator. Each operand carries a valid bit. During fill and drain the zero padding moves through the grid, but no cell adds it. When the last cell has its final product, a one-cycle done pulse is issued. The nine results then stay unchanged until the next start.

The operand and result buses are not streams, so there is no valid/ready handshake and no back-pressure. Both matrices are sampled in the start cycle and ignored at all other times. The results are plain held registers. A start during a computation aborts it and begins a new one.

Top module: `sysmm_grid`

## Requirements
- R1: After a computation, result element (r,c) equals the exact signed sum over k of A[r][k]*B[k][c]. Operand element (r,c) sits at bits [(r*3+c)*8 +: 8] of its bus, and result (r,c) sits at bits [(r*3+c)*20 +: 20] of the result bus, as 8-bit and 20-bit two's complement.
- R2: Start is sampled at a clock edge, called step 0. That edge clears all nine results to zero and captures both operand buses.
- R3: Cell (r,c) receives operand pair k at step r+c+k+1 and adds it at that edge. After step s, result (r,c) therefore holds the partial sum over k from 0 to min(2, s-r-c-1). Element (0,0) gets its first product at step 1, element (r,c) is final at step r+c+3, and element (2,2) is final at step 7.
- R4: Done goes high after the step-7 edge and is low at every other time during a run.
- R5: Done lasts exactly one cycle.
- R6: When no start is given, the results hold their values indefinitely after done, and changes on the operand buses have no effect on them.
- R7: A start that arrives during a computation discards the run in progress. The new computation then follows R2 to R4 exactly, counted from the new start.
- R8: Extreme operands produce no overflow. This covers all +127, all -128, and mixed +127/-128 values.
- R9: After reset, done is low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures operands, clears results, begins a run |
| a_mat | input | 72 | Matrix A, nine signed 8-bit elements, row-major |
| b_mat | input | 72 | Matrix B, nine signed 8-bit elements, row-major |
| done | output | 1 | One-cycle pulse when all results are final |
| c_res | output | 180 | Nine signed 20-bit results, row-major |

## Verification
The bench models the grid behaviourally. After every step it knows which partial sum each of the nine elements should hold, and it checks all of them, along with done, on every clock. Identity and zero matrices expose misrouted operands and accumulation of padding. Random signed matrices expose sign-extension and ordering faults. Matrices of all +127, all -128, and mixed extremes test the accumulator width. A restart in the middle of a run shows whether any stale operands left in the grid leak into the new result.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  // Edge (counted from the start edge) at which the final cell receives its last pair.
  function automatic int final_step(int n);
    return 3 * n - 2;
  endfunction
endpackage

// File: rtl/sysmm_skew.sv
// Edge feeder for one row of A or one column of B.
// Element e of the lane is presented while the step counter equals LANE + e.
module sysmm_skew #(
  parameter int N    = 3,
  parameter int DW   = 8,
  parameter int CW   = 4,
  parameter int LANE = 0
) (
  input  logic [N*DW-1:0]       vec,
  input  logic [CW-1:0]         cnt,
  input  logic                  run,
  output logic signed [DW-1:0]  dat,
  output logic                  vld
);
  int pos;
  always_comb begin
    pos = int'(cnt) - LANE;
    dat = '0;
    vld = 1'b0;
    if (run && pos >= 0 && pos < N) begin
      dat = $signed(vec[pos*DW +: DW]);
      vld = 1'b1;
    end
  end
endmodule

// File: rtl/sysmm_cell.sv
// One grid cell: latches and forwards operands, accumulates valid pairs.
module sysmm_cell #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [DW-1:0] a_i,
  input  logic                 a_vi,
  input  logic signed [DW-1:0] b_i,
  input  logic                 b_vi,
  output logic signed [DW-1:0] a_o,
  output logic                 a_vo,
  output logic signed [DW-1:0] b_o,
  output logic                 b_vo,
  output logic signed [AW-1:0] acc_o
);
  logic signed [2*DW-1:0] prod;
  assign prod = a_i * b_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_o   <= '0;
      a_vo  <= 1'b0;
      b_o   <= '0;
      b_vo  <= 1'b0;
      acc_o <= '0;
    end else if (clr) begin
      a_o   <= '0;
      a_vo  <= 1'b0;
      b_o   <= '0;
      b_vo  <= 1'b0;
      acc_o <= '0;
    end else begin
      a_o  <= a_i;
      a_vo <= a_vi;
      b_o  <= b_i;
      b_vo <= b_vi;
      if (a_vi && b_vi)
        acc_o <= acc_o + AW'(prod);
    end
  end
endmodule

// File: rtl/sysmm_grid.sv
module sysmm_grid #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N*DW-1:0] a_mat,
  input  logic [N*N*DW-1:0] b_mat,
  output logic              done,
  output logic [N*N*AW-1:0] c_res
);
  localparam int LAST = sysmm_pkg::final_step(N) - 1;  // counter value at the final edge
  localparam int CW   = $clog2(3 * N);

  logic [N*N*DW-1:0] a_q, b_q;
  logic [CW-1:0]     cnt;
  logic              run;

  // operand capture and step sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        a_q <= a_mat;
        b_q <= b_mat;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (int'(cnt) == LAST) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  logic signed [DW-1:0] a_bus  [N][N+1];
  logic                 a_vbus [N][N+1];
  logic signed [DW-1:0] b_bus  [N+1][N];
  logic                 b_vbus [N+1][N];
  logic [N*DW-1:0]      b_col  [N];

  for (genvar r = 0; r < N; r++) begin : g_rowfeed
    sysmm_skew #(.N(N), .DW(DW), .CW(CW), .LANE(r)) u_rowfeed (
      .vec (a_q[r*N*DW +: N*DW]),
      .cnt (cnt),
      .run (run),
      .dat (a_bus[r][0]),
      .vld (a_vbus[r][0])
    );
  end

  for (genvar c = 0; c < N; c++) begin : g_colfeed
    for (genvar k = 0; k < N; k++) begin : g_gather
      assign b_col[c][k*DW +: DW] = b_q[(k*N+c)*DW +: DW];
    end
    sysmm_skew #(.N(N), .DW(DW), .CW(CW), .LANE(c)) u_colfeed (
      .vec (b_col[c]),
      .cnt (cnt),
      .run (run),
      .dat (b_bus[0][c]),
      .vld (b_vbus[0][c])
    );
  end

  for (genvar r = 0; r < N; r++) begin : g_r
    for (genvar c = 0; c < N; c++) begin : g_c
      logic signed [AW-1:0] acc;
      sysmm_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .a_i   (a_bus[r][c]),
        .a_vi  (a_vbus[r][c]),
        .b_i   (b_bus[r][c]),
        .b_vi  (b_vbus[r][c]),
        .a_o   (a_bus[r][c+1]),
        .a_vo  (a_vbus[r][c+1]),
        .b_o   (b_bus[r+1][c]),
        .b_vo  (b_vbus[r+1][c]),
        .acc_o (acc)
      );
      assign c_res[(r*N+c)*AW +: AW] = acc;
    end
  end
endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
  parameter int N  = 3,
  parameter int AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              run,
  input logic [N*N*AW-1:0] c_res
);
  int   since;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 0;
      armed <= 1'b0;
    end else if (start) begin
      since <= 0;
      armed <= 1'b1;
    end else if (done) begin
      armed <= 1'b0;
    end else if (armed && since < 1000) begin
      since <= since + 1;
    end
  end

  // R2: results are cleared by start
  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (c_res == '0));

  // R4: done only at the final step counted from start
  p_done_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (armed && since == sysmm_pkg::final_step(N)));

  // R5: done is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: results hold while idle
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(c_res));
endmodule

bind sysmm_grid sysmm_chk #(.N(N), .AW(AW)) u_sysmm_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .run   (run),
  .c_res (c_res)
);

// File: tb/test_sysmm_grid.sv
module test_sysmm_grid;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [71:0]  a_mat = '0;
  logic [71:0]  b_mat = '0;
  logic         done;
  logic [179:0] c_res;

  int n_tests = 0;
  int n_fail  = 0;
  int ma [3][3];
  int mb [3][3];

  always #2 clk = ~clk;

  sysmm_grid i_sysmm_grid (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_mat(a_mat), .b_mat(b_mat), .done(done), .c_res(c_res)
  );

  function automatic int got(int r, int c);
    logic signed [19:0] v;
    v = c_res[(r*3+c)*20 +: 20];
    return int'(v);
  endfunction

  // behavioural partial product after step s
  function automatic int want(int r, int c, int s);
    int sum = 0;
    for (int k = 0; k < 3; k++)
      if (k <= s - r - c - 1) sum += ma[r][k] * mb[k][c];
    return sum;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pack();
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        a_mat[(r*3+c)*8 +: 8] = 8'(ma[r][c]);
        b_mat[(r*3+c)*8 +: 8] = 8'(mb[r][c]);
      end
  endtask

  // called at a negedge; abort_at > 0 stops after that step (for R7)
  task automatic run_case(input string tag, input int abort_at);
    int fin [3][3];
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        check(got(r, c) == 0, {"R2 clear ", tag}, got(r, c), 0);
    check(done == 1'b0, {"R4 done early ", tag}, done, 0);
    for (int s = 1; s <= 10; s++) begin
      @(negedge clk);
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          check(got(r, c) == want(r, c, s), {"R3/R1 partial ", tag},
                got(r, c), want(r, c, s));
      check(done == (s == 7), {"R4/R5 done ", tag}, done, int'(s == 7));
      if (abort_at == s) return;
    end
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) fin[r][c] = want(r, c, 99);
    // R6: operand buses are ignored once idle
    a_mat = {$urandom, $urandom, $urandom};
    b_mat = {$urandom, $urandom, $urandom};
    repeat (4) @(negedge clk);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        check(got(r, c) == fin[r][c], {"R6 hold ", tag}, got(r, c), fin[r][c]);
    check(done == 1'b0, {"R5 no refire ", tag}, done, 0);
  endtask

  task automatic fill(input int mode);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        case (mode)
          0: begin ma[r][c] = (r == c); mb[r][c] = r*3 + c - 4; end
          1: begin ma[r][c] = 0; mb[r][c] = 0; end
          2: begin ma[r][c] = 127; mb[r][c] = 127; end
          3: begin ma[r][c] = -128; mb[r][c] = -128; end
          4: begin ma[r][c] = 127; mb[r][c] = -128; end
          default: begin
            ma[r][c] = int'($signed(8'($urandom)));
            mb[r][c] = int'($signed(8'($urandom)));
          end
        endcase
      end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        check(got(r, c) == 0, "R9 reset result", got(r, c), 0);
    check(done == 1'b0, "R9 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    fill(0); run_case("identity", 0);
    fill(1); run_case("zero", 0);
    fill(2); run_case("R8 all +127", 0);
    fill(3); run_case("R8 all -128", 0);
    fill(4); run_case("R8 mixed extremes", 0);
    for (int t = 0; t < 6; t++) begin
      fill(5); run_case("R1 random", 0);
    end
    // R7: restart in the middle of a run
    fill(5); run_case("R7 aborted", 4);
    fill(3); run_case("R7 restarted", 0);
    fill(5); run_case("R7 aborted late", 6);
    fill(5); run_case("R7 restarted late", 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule